// File: doc/BRIEF.md
# Address-Keyed Request Wait Buffer

This block sits beside a cache controller's input queue and holds requests that must wait because their cache line already has an operation outstanding. When the controller decides a request has to wait, it pushes the request together with its line address into the buffer. The request leaves the queue head at once, so requests to other lines keep flowing. A parked request does nothing while it waits. It is not retried each cycle.

When the outstanding operation completes, the controller pulses a wakeup with the line address. Every request parked on that address becomes eligible for replay. Eligible requests are merged back into the controller's input path ahead of fresh queue traffic, oldest first. The request payload is opaque to the block.

Each storage slot is a small state machine with three states:
- SLOT_FREE: the slot is empty.
- SLOT_WAIT: the slot holds a parked request that is asleep.
- SLOT_WOKEN: the slot holds a request that has been released and waits for the output.

A slot moves between these states through four transitions:
- park (SLOT_FREE to SLOT_WAIT).
- wake (SLOT_WAIT to SLOT_WOKEN, on an address match).
- replay (SLOT_WOKEN leaves through the output).
- shift. When a request is replayed, every younger slot moves down one place. A slot keeps its state while it shifts, so slot order is always park order.

Top module: `addr_wait_buffer`

## Requirements
- R1: After reset the buffer is empty. park_ready is 1, out_replay is 0, and the output carries only the input queue.
- R2: A request is accepted when park_valid and park_ready are both 1 at a clock edge. An accepted request never appears at the output unless a wakeup for its address arrives.
- R3: A wakeup (wake_valid with wake_addr) releases every parked request whose address equals wake_addr. Requests parked on other addresses stay parked. The first released request is on the output in the cycle after the wakeup edge.
- R4: Released requests leave through the output oldest-parked first, one per cycle while out_ready is 1.
- R5: While any released request is waiting, the output carries it with out_replay at 1, and in_ready is 0.
- R6: While no released request is waiting, the output mirrors the input queue combinationally. out_valid equals in_valid, out_addr and out_data equal in_addr and in_data, in_ready equals out_ready, and out_replay is 0.
- R7: park_ready is 0 whenever DEPTH requests are held, and a park attempt made then stores nothing. After a replay frees a slot, park_ready is 1 in the following cycle.
- R8: A wakeup whose address matches no parked request changes nothing.
- R9: A request parked at the same edge as a wakeup for its own address is not released by that wakeup. It waits for a later wakeup.
- R10: While out_ready is 0, the request on offer stays on the output and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| park_valid | input | 1 | Request to park a request |
| park_addr | input | AW | Line address the request waits on |
| park_data | input | DW | Opaque request payload |
| park_ready | output | 1 | A free slot exists; park accepted |
| wake_valid | input | 1 | Wakeup pulse |
| wake_addr | input | AW | Line address being woken |
| in_valid | input | 1 | Fresh request from the input queue |
| in_addr | input | AW | Fresh request address |
| in_data | input | DW | Fresh request payload |
| in_ready | output | 1 | Fresh request consumed |
| out_valid | output | 1 | Request offered to the controller |
| out_addr | output | AW | Offered request address |
| out_data | output | DW | Offered request payload |
| out_replay | output | 1 | Offered request is a replay |
| out_ready | input | 1 | Controller takes the offered request |

## Verification
The bench parks requests on interleaved addresses and wakes one address. It checks that exactly that address's requests come back, in park order. A design that woke only one request, or let others leak out, would give too few or too many replays. A design that lost the order would replay the wrong payload.

The bench also checks three edge-of-timing cases:
- A wakeup for an address with nothing parked. A wrong design would spuriously start a replay.
- A park at the same edge as a wakeup for its own address. A wrong design would release the new request early.
- A park attempt against a full buffer. A wrong design would overwrite a slot or hold a phantom entry, which would show up as an extra or corrupted replay.

Back-pressure during replay and the arbitration against fresh input are checked. A design that dropped the held request, or let the queue past a pending replay, would fail these checks.

// File: rtl/awb_pkg.sv
package awb_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE,
        SLOT_WAIT,
        SLOT_WOKEN
    } slot_st_t;

    typedef enum logic [1:0] {
        MV_KEEP,
        MV_SHIFT,
        MV_LOAD,
        MV_CLEAR
    } slot_mv_t;
endpackage

// File: rtl/awb_slot.sv
module awb_slot
    import awb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_mv_t      mv,
    input  slot_st_t      up_st,
    input  logic [AW-1:0] up_addr,
    input  logic [DW-1:0] up_data,
    input  logic [AW-1:0] new_addr,
    input  logic [DW-1:0] new_data,
    input  logic          wake_valid,
    input  logic [AW-1:0] wake_addr,
    output slot_st_t      st,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    slot_st_t      st_q, st_d, src_st;
    logic [AW-1:0] addr_q, addr_d, src_addr;
    logic [DW-1:0] data_q, data_d, src_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SLOT_FREE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    always_comb begin
        src_st   = (mv == MV_SHIFT) ? up_st   : st_q;
        src_addr = (mv == MV_SHIFT) ? up_addr : addr_q;
        src_data = (mv == MV_SHIFT) ? up_data : data_q;
        st_d     = st_q;
        addr_d   = addr_q;
        data_d   = data_q;
        unique case (mv)
            MV_KEEP, MV_SHIFT: begin
                addr_d = src_addr;
                data_d = src_data;
                if (src_st == SLOT_WAIT && wake_valid && src_addr == wake_addr)
                    st_d = SLOT_WOKEN;
                else
                    st_d = src_st;
            end
            MV_LOAD: begin
                st_d   = SLOT_WAIT;
                addr_d = new_addr;
                data_d = new_data;
            end
            MV_CLEAR: st_d = SLOT_FREE;
            default:  st_d = st_q;
        endcase
    end

    assign st   = st_q;
    assign addr = addr_q;
    assign data = data_q;
endmodule

// File: rtl/awb_oldest.sv
module awb_oldest #(
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic [DEPTH-1:0] woken,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (woken[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/addr_wait_buffer.sv
module addr_wait_buffer
    import awb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          park_valid,
    input  logic [AW-1:0] park_addr,
    input  logic [DW-1:0] park_data,
    output logic          park_ready,
    input  logic          wake_valid,
    input  logic [AW-1:0] wake_addr,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic          out_replay,
    input  logic          out_ready
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    slot_st_t      st     [DEPTH];
    logic [AW-1:0] sa     [DEPTH];
    logic [DW-1:0] sd     [DEPTH];
    slot_st_t      up_st  [DEPTH];
    logic [AW-1:0] up_a   [DEPTH];
    logic [DW-1:0] up_d   [DEPTH];
    slot_mv_t      mv     [DEPTH];
    logic [DEPTH-1:0] woken;

    logic [CW-1:0] cnt_q, cnt_d, base;
    logic          rep_any, push, pop;
    logic [IW-1:0] rep_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i < DEPTH - 1) begin : g_up
            assign up_st[i] = st[i+1];
            assign up_a[i]  = sa[i+1];
            assign up_d[i]  = sd[i+1];
        end else begin : g_top
            assign up_st[i] = SLOT_FREE;
            assign up_a[i]  = '0;
            assign up_d[i]  = '0;
        end
        assign woken[i] = (st[i] == SLOT_WOKEN);
        awb_slot #(.AW(AW), .DW(DW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .mv         (mv[i]),
            .up_st      (up_st[i]),
            .up_addr    (up_a[i]),
            .up_data    (up_d[i]),
            .new_addr   (park_addr),
            .new_data   (park_data),
            .wake_valid (wake_valid),
            .wake_addr  (wake_addr),
            .st         (st[i]),
            .addr       (sa[i]),
            .data       (sd[i])
        );
    end

    awb_oldest #(.DEPTH(DEPTH), .IW(IW)) u_oldest (
        .woken (woken),
        .found (rep_any),
        .idx   (rep_idx)
    );

    assign park_ready = (cnt_q != CW'(DEPTH));
    assign push       = park_valid && park_ready;
    assign pop        = rep_any && out_ready;
    assign base       = cnt_q - CW'(pop);
    assign cnt_d      = cnt_q + CW'(push) - CW'(pop);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic src_ok, shift;
            shift  = pop && (i >= int'(rep_idx));
            src_ok = shift ? ((i + 1) < int'(cnt_q)) : (i < int'(cnt_q));
            if (src_ok)
                mv[i] = shift ? MV_SHIFT : MV_KEEP;
            else if (push && i == int'(base))
                mv[i] = MV_LOAD;
            else
                mv[i] = MV_CLEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_comb begin
        out_replay = rep_any;
        out_valid  = rep_any || in_valid;
        out_addr   = rep_any ? sa[rep_idx] : in_addr;
        out_data   = rep_any ? sd[rep_idx] : in_data;
        in_ready   = out_ready && !rep_any;
    end
endmodule

// File: rtl/awb_chk.sv
module awb_chk #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          park_valid,
    input logic          park_ready,
    input logic          wake_valid,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_replay,
    input logic          out_ready
);
    localparam int OW = $clog2(DEPTH + 1) + 1;
    logic [OW-1:0] occ;

    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else occ <= occ + OW'(park_valid && park_ready)
                        - OW'(out_valid && out_ready && out_replay);
    end

    a_r7_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        park_ready == (occ < OW'(DEPTH)));
    a_r2_wake_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_replay) |-> $past(wake_valid));
    a_r5_replay_first: assert property (@(posedge clk) disable iff (!rst_n)
        out_replay |-> (!in_ready && out_valid));
    a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !out_replay |-> ((out_valid == in_valid) && (in_ready == out_ready)));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_replay && !out_ready) |=> out_replay);
    a_r1_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !out_replay);
endmodule

bind addr_wait_buffer awb_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .park_valid (park_valid),
    .park_ready (park_ready),
    .wake_valid (wake_valid),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_replay (out_replay),
    .out_ready  (out_ready)
);

// File: tb/sim_addr_wait_buffer.sv
module sim_addr_wait_buffer;
    localparam int AW = 16, DW = 32, DEPTH = 8;
    localparam logic [15:0] LA = 16'h0A10, LB = 16'h0B20, LC = 16'h0C30;
    localparam logic [15:0] LD = 16'h0D40, LE = 16'h0E50;
    // vector: {address, payload, release rank on a wakeup of LA (0 = not released)}
    localparam logic [51:0] VEC [6] = '{
        {LA, 32'h1000_0000, 4'd1},
        {LB, 32'h1000_0001, 4'd0},
        {LA, 32'h1000_0002, 4'd2},
        {LC, 32'h1000_0003, 4'd0},
        {LA, 32'h1000_0004, 4'd3},
        {LB, 32'h1000_0005, 4'd0}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, park_valid, park_ready, wake_valid, in_valid, in_ready;
    logic out_valid, out_replay, out_ready;
    logic [AW-1:0] park_addr, wake_addr, in_addr, out_addr;
    logic [DW-1:0] park_data, in_data, out_data;

    int n_chk = 0, n_fail = 0;

    addr_wait_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; park_valid = 0; park_addr = '0; park_data = '0;
        wake_valid = 0; wake_addr = '0; in_valid = 0; in_addr = '0; in_data = '0;
        out_ready = 0;
        repeat (3) step();
        rst_n = 1;
        step(); settle();
        check("R1 park_ready", park_ready, 1);
        check("R1 out_replay", out_replay, 0);
        check("R1 out_valid", out_valid, 0);

        // R6 passthrough
        step(); in_valid = 1; in_addr = 16'h7777; in_data = 32'hCAFE_0001; out_ready = 1; settle();
        check("R6 out_valid", out_valid, 1);
        check("R6 out_data", out_data, 32'hCAFE_0001);
        check("R6 out_addr", out_addr, 16'h7777);
        check("R6 in_ready", in_ready, 1);
        out_ready = 0; settle();
        check("R6 in_ready low", in_ready, 0);
        in_valid = 0;

        // table walk: park each vector
        for (int i = 0; i < 6; i++) begin
            step();
            park_valid = 1; park_addr = VEC[i][51:36]; park_data = VEC[i][35:4];
            settle();
            check("R2 park_ready", park_ready, 1);
        end
        step(); park_valid = 0;
        for (int i = 0; i < 3; i++) begin
            step(); settle();
            check("R2 dormant", out_replay, 0);
        end

        // R8: wake an unused address
        step(); wake_valid = 1; wake_addr = LD;
        step(); wake_valid = 0; settle();
        check("R8 no effect", out_replay, 0);

        // R3/R4/R5/R10: wake LA with back-pressure
        step(); wake_valid = 1; wake_addr = LA; in_valid = 1; in_addr = 16'h1234; in_data = 32'hFEED_0000;
        step(); wake_valid = 0; settle();
        check("R3 released", out_replay, 1);
        check("R5 in_ready", in_ready, 0);
        check("R5 out_valid", out_valid, 1);
        step(); settle();
        check("R10 held", out_data, VEC[0][35:4]);
        out_ready = 1;
        for (int r = 1; r <= 3; r++) begin
            for (int i = 0; i < 6; i++) begin
                if (VEC[i][3:0] == 4'(r)) begin
                    settle();
                    check("R4 order", out_data, VEC[i][35:4]);
                    check("R3 addr", out_addr, LA);
                    step();
                end
            end
        end
        settle();
        check("R3 others parked", out_replay, 0);
        check("R6 resumes", out_data, 32'hFEED_0000);
        in_valid = 0;

        // R9: park on LB in the same edge as a wakeup of LB
        step(); park_valid = 1; park_addr = LB; park_data = 32'h2000_00AA; wake_valid = 1; wake_addr = LB;
        step(); park_valid = 0; wake_valid = 0; settle();
        check("R3 LB first", out_data, VEC[1][35:4]);
        step(); settle();
        check("R3 LB second", out_data, VEC[5][35:4]);
        step(); settle();
        check("R9 same-edge park stays", out_replay, 0);
        step(); wake_valid = 1; wake_addr = LB;
        step(); wake_valid = 0; settle();
        check("R9 later wake", out_data, 32'h2000_00AA);
        step(); wake_valid = 1; wake_addr = LC; settle();
        check("R9 popped", out_replay, 0);
        step(); wake_valid = 0; settle();
        check("R3 LC", out_data, VEC[3][35:4]);
        step(); settle();
        check("R3 empty", out_replay, 0);

        // R7: fill, refuse, drain
        out_ready = 0;
        for (int i = 0; i < DEPTH; i++) begin
            step(); park_valid = 1; park_addr = LE; park_data = 32'h3000_0000 + 32'(i);
        end
        step(); park_valid = 0; settle();
        check("R7 full", park_ready, 0);
        step(); park_valid = 1; park_data = 32'hDEAD_BEEF; settle();
        check("R7 full refuse", park_ready, 0);
        step(); park_valid = 0; wake_valid = 1; wake_addr = LE; out_ready = 1;
        step(); wake_valid = 0;
        for (int i = 0; i < DEPTH; i++) begin
            settle();
            check("R7 drain order", out_data, 32'h3000_0000 + 32'(i));
            if (i == 1) check("R7 slot freed", park_ready, 1);
            step();
        end
        settle();
        check("R7 no phantom", out_replay, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule